// File: doc/BRIEF.md
# Busy-Aware Accept Conflict Checker

This block decides whether a pending trigger decision may be sent out while some destination sections report that they are full. Each of the `N` destination sections (128 by default) raises its busy line when all eight of its local event buffers are occupied. Such a section must not receive another accept. A decision is held back only when at least one section that takes part in the running configuration is busy and is also named by the decision's accept vector. Rejects to busy sections are always allowed, and so are accepts to sections that are not busy.

A participation mask selects which sections belong to the running configuration. Busy lines from sections outside the mask are ignored. The registered `conflict_o` output goes to the decision sequencer, which waits while it is high. Two saturating monitor counters record stalls that are caused by busy sections. One counts every clock tick in which the sequencer waits while a conflict exists. The other counts the decision cycles that had at least one such tick. A synchronous clear input resets both counters.

Top module: `accept_busy_guard`

## Requirements
- R1: After reset, `conflict_o` is 0, both counters are 0 and `part_mask_o` is all ones, so every section participates.
- R2: A clock edge with `part_wr_i` high loads `part_data_i` into the participation mask, and `part_mask_o` shows the new mask after that edge. With `part_wr_i` low the mask keeps its value.
- R3: Bit k of `accept_i`, `busy_i` and the mask all refer to section k. If some k has all three bits high in a cycle, `conflict_o` is 1 after the next clock edge.
- R4: `reject_i` has no effect. If no section has its accept, busy and mask bits all high together (for example when only rejects go to busy sections, when accepts go only to idle sections, or when the busy section is masked out), `conflict_o` is 0 after the next edge.
- R5: A hold tick is a cycle in which `waiting_i` is high and the R3 condition holds. `hold_ticks_o` increases by exactly one after each hold tick and does not change after any other cycle.
- R6: At an edge with `cycle_end_i` high, `held_cycles_o` increases by one if any hold tick occurred since the previous `cycle_end_i` or since reset. A hold tick in that same cycle also counts. The pending record is then discarded.
- R7: Both counters saturate at all ones and never wrap.
- R8: `clear_i` sets both counters to 0 at the next edge and wins over an increment in the same cycle. It does not discard a hold tick that is already pending for R6.
- R9: A mask write takes effect for conflict evaluation in the cycle after the write. The cycle that contains the write is judged with the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accept_i | input | N | Sections told to accept by the pending decision |
| reject_i | input | N | Sections told to reject; does not affect the result |
| busy_i | input | N | Section busy lines (all local buffers full) |
| part_wr_i | input | 1 | Load strobe for the participation mask |
| part_data_i | input | N | New participation mask |
| waiting_i | input | 1 | Sequencer is waiting to distribute the decision |
| cycle_end_i | input | 1 | Pulse that closes a decision cycle |
| clear_i | input | 1 | Synchronous clear of both counters |
| conflict_o | output | 1 | Registered hold request to the sequencer |
| part_mask_o | output | N | Current participation mask |
| hold_ticks_o | output | CNT_W | Saturating count of hold ticks |
| held_cycles_o | output | CNT_W | Saturating count of decision cycles that had a hold |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a hold tick arrives together with `cycle_end_i`, and that decision cycle must still be counted. In the second, `clear_i` arrives together with a hold tick: the counters must read zero afterwards, while the pending record survives and is counted at the next cycle end. The bench drives both coincidences on purpose and compares the outputs against a model that follows the requirements. It also writes the mask in the same cycle as a conflicting accept, which checks that the old mask is used for that cycle.

// File: rtl/abg_pkg.sv
package abg_pkg;

    localparam int ABG_DEF_SECTIONS = 128;
    localparam int ABG_DEF_CNT_W    = 16;
    localparam int ABG_DEF_GROUP    = 16;

    // increment requests handed to the monitor counters
    typedef struct packed {
        logic tick;
        logic cycle;
    } abg_inc_t;

endpackage

// File: rtl/abg_match.sv
module abg_match #(
    parameter int N   = 128,
    parameter int GRP = 16
) (
    input  logic [N-1:0] acc_i,
    input  logic [N-1:0] bsy_i,
    input  logic [N-1:0] en_i,
    output logic         hit_o
);

    localparam int NGRP = (N + GRP - 1) / GRP;
    localparam int PADW = NGRP * GRP;

    logic [PADW-1:0] acc_pad;
    logic [PADW-1:0] bsy_pad;
    logic [PADW-1:0] en_pad;
    logic [NGRP-1:0] grp_hit;

    assign acc_pad = PADW'(acc_i);
    assign bsy_pad = PADW'(bsy_i);
    assign en_pad  = PADW'(en_i);

    // one reduction per group keeps the final OR shallow
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_hit[g] = |(acc_pad[g*GRP +: GRP]
                            & bsy_pad[g*GRP +: GRP]
                            & en_pad[g*GRP +: GRP]);
    end

    assign hit_o = |grp_hit;

endmodule

// File: rtl/abg_satcnt.sv
module abg_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i && (st_q.cnt != MAXV)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/accept_busy_guard.sv
module accept_busy_guard
    import abg_pkg::*;
#(
    parameter int N     = ABG_DEF_SECTIONS,
    parameter int CNT_W = ABG_DEF_CNT_W,
    parameter int GRP   = ABG_DEF_GROUP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     accept_i,
    input  logic [N-1:0]     reject_i,
    input  logic [N-1:0]     busy_i,
    input  logic             part_wr_i,
    input  logic [N-1:0]     part_data_i,
    input  logic             waiting_i,
    input  logic             cycle_end_i,
    input  logic             clear_i,
    output logic             conflict_o,
    output logic [N-1:0]     part_mask_o,
    output logic [CNT_W-1:0] hold_ticks_o,
    output logic [CNT_W-1:0] held_cycles_o
);

    typedef struct packed {
        logic         conflict;
        logic         seen;
        logic [N-1:0] mask;
    } guard_st_t;

    guard_st_t st_d, st_q;
    abg_inc_t  inc_d;
    logic      hit;
    logic      unused_reject;

    // reject targets never gate distribution
    assign unused_reject = ^reject_i;

    abg_match #(
        .N   (N),
        .GRP (GRP)
    ) u_match (
        .acc_i (accept_i),
        .bsy_i (busy_i),
        .en_i  (st_q.mask),
        .hit_o (hit)
    );

    always_comb begin
        st_d          = st_q;
        inc_d.tick    = hit && waiting_i;
        inc_d.cycle   = cycle_end_i && (st_q.seen || inc_d.tick);
        st_d.conflict = hit;
        if (cycle_end_i) begin
            st_d.seen = 1'b0;
        end else if (inc_d.tick) begin
            st_d.seen = 1'b1;
        end
        if (part_wr_i) begin
            st_d.mask = part_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.conflict <= 1'b0;
            st_q.seen     <= 1'b0;
            st_q.mask     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    abg_satcnt #(
        .W (CNT_W)
    ) u_tick_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clear_i),
        .inc_i (inc_d.tick),
        .cnt_o (hold_ticks_o)
    );

    abg_satcnt #(
        .W (CNT_W)
    ) u_cycle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clear_i),
        .inc_i (inc_d.cycle),
        .cnt_o (held_cycles_o)
    );

    assign conflict_o  = st_q.conflict;
    assign part_mask_o = st_q.mask;

endmodule

// File: rtl/abg_checker.sv
module abg_checker #(
    parameter int N     = 128,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     accept_i,
    input logic [N-1:0]     busy_i,
    input logic             part_wr_i,
    input logic             waiting_i,
    input logic             cycle_end_i,
    input logic             clear_i,
    input logic             conflict_o,
    input logic [N-1:0]     part_mask_o,
    input logic [CNT_W-1:0] hold_ticks_o,
    input logic [CNT_W-1:0] held_cycles_o
);

    localparam logic [CNT_W-1:0] TOP = '1;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !part_wr_i |=> $stable(part_mask_o)); // R2

    AST_CONFLICT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (|(accept_i & busy_i & part_mask_o)) |=> conflict_o); // R3

    AST_NO_FALSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(accept_i & busy_i & part_mask_o)) |=> !conflict_o); // R4

    AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !waiting_i) |=> $stable(hold_ticks_o)); // R5

    AST_CYCLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !cycle_end_i) |=> $stable(held_cycles_o)); // R6

    AST_TICK_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && hold_ticks_o == TOP) |=> hold_ticks_o == TOP); // R7

    AST_CYCLE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && held_cycles_o == TOP) |=> held_cycles_o == TOP); // R7

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (hold_ticks_o == '0 && held_cycles_o == '0)); // R8

endmodule

bind accept_busy_guard abg_checker #(
    .N     (N),
    .CNT_W (CNT_W)
) u_abg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept_i      (accept_i),
    .busy_i        (busy_i),
    .part_wr_i     (part_wr_i),
    .waiting_i     (waiting_i),
    .cycle_end_i   (cycle_end_i),
    .clear_i       (clear_i),
    .conflict_o    (conflict_o),
    .part_mask_o   (part_mask_o),
    .hold_ticks_o  (hold_ticks_o),
    .held_cycles_o (held_cycles_o)
);

// File: tb/accept_busy_guard_tb.sv
module accept_busy_guard_tb;

    localparam int N      = 128;
    localparam int CNT_W  = 6;
    localparam int CLK_NS = 10;
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct {
        logic             conf;
        logic [CNT_W-1:0] ticks;
        logic [CNT_W-1:0] cycs;
        logic [N-1:0]     mask;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     accept_i = '0;
    logic [N-1:0]     reject_i = '0;
    logic [N-1:0]     busy_i = '0;
    logic             part_wr_i = 1'b0;
    logic [N-1:0]     part_data_i = '0;
    logic             waiting_i = 1'b0;
    logic             cycle_end_i = 1'b0;
    logic             clear_i = 1'b0;
    logic             conflict_o;
    logic [N-1:0]     part_mask_o;
    logic [CNT_W-1:0] hold_ticks_o;
    logic [CNT_W-1:0] held_cycles_o;

    int total = 0;
    int bad   = 0;

    exp_t sb_q[$];

    logic [N-1:0]     m_mask  = '1;
    logic             m_seen  = 1'b0;
    logic [CNT_W-1:0] m_ticks = '0;
    logic [CNT_W-1:0] m_cycs  = '0;

    always #(CLK_NS/2) clk = ~clk;

    accept_busy_guard #(
        .N     (N),
        .CNT_W (CNT_W)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_i      (accept_i),
        .reject_i      (reject_i),
        .busy_i        (busy_i),
        .part_wr_i     (part_wr_i),
        .part_data_i   (part_data_i),
        .waiting_i     (waiting_i),
        .cycle_end_i   (cycle_end_i),
        .clear_i       (clear_i),
        .conflict_o    (conflict_o),
        .part_mask_o   (part_mask_o),
        .hold_ticks_o  (hold_ticks_o),
        .held_cycles_o (held_cycles_o)
    );

    task automatic check_bit(string tag, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_cnt(string tag, string what, logic [CNT_W-1:0] act,
                             logic [CNT_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_mask(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s mask actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(logic [N-1:0] acc, logic [N-1:0] rej, logic [N-1:0] bsy,
                        logic wt, logic ce, logic clr, logic wr,
                        logic [N-1:0] wdata, string tag);
        exp_t e;
        logic hit;
        logic tick;
        @(negedge clk);
        #1;
        accept_i    = acc;
        reject_i    = rej;
        busy_i      = bsy;
        waiting_i   = wt;
        cycle_end_i = ce;
        clear_i     = clr;
        part_wr_i   = wr;
        part_data_i = wdata;
        hit  = |(acc & bsy & m_mask);
        tick = hit && wt;
        if (clr) begin
            m_ticks = '0;
            m_cycs  = '0;
        end else begin
            if (tick && m_ticks != TOP) m_ticks = m_ticks + 1'b1;
            if (ce && (m_seen || tick) && m_cycs != TOP) m_cycs = m_cycs + 1'b1;
        end
        if (ce) m_seen = 1'b0;
        else if (tick) m_seen = 1'b1;
        if (wr) m_mask = wdata;
        e.conf  = hit;
        e.ticks = m_ticks;
        e.cycs  = m_cycs;
        e.mask  = m_mask;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // monitor: outputs settled after the edge, compared half a period later
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check_bit(e.tag, "conflict", conflict_o, e.conf);
            check_cnt(e.tag, "hold_ticks", hold_ticks_o, e.ticks);
            check_cnt(e.tag, "held_cycles", held_cycles_o, e.cycs);
            check_mask(e.tag, part_mask_o, e.mask);
        end
    end

    function automatic logic [N-1:0] one(int k);
        return (N'(1)) << k;
    endfunction

    initial begin
        #(CLK_NS * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check_bit("R1", "conflict", conflict_o, 1'b0);
        check_cnt("R1", "hold_ticks", hold_ticks_o, '0);
        check_cnt("R1", "held_cycles", held_cycles_o, '0);
        check_mask("R1", part_mask_o, '1);
        @(negedge clk);
        rst_n = 1'b1;

        step('0, '0, '0, 0, 0, 0, 0, '0, "R1");
        // R3: accept meets busy at section 5
        step(one(5), '0, one(5), 0, 0, 0, 0, '0, "R3");
        // R4: accept to idle section, reject to busy one
        step(one(5), one(6), one(6), 1, 0, 0, 0, '0, "R4");
        // R4: rejects to every section while all are busy
        step('0, '1, '1, 1, 0, 0, 0, '0, "R4");
        // R3: boundary sections 0 and 127
        step(one(0), '0, one(0), 0, 0, 0, 0, '0, "R3");
        step(one(N-1), '0, one(N-1) | one(3), 0, 0, 0, 0, '0, "R3");
        // R9: mask write in the same cycle as a conflict uses the old mask
        step(one(5), '0, one(5), 0, 0, 0, 1, ~one(5), "R9");
        // R2 and R4: masked-out busy section no longer blocks
        step(one(5), '0, one(5), 1, 0, 0, 0, '0, "R2");
        step(one(5) | one(9), '0, one(5) | one(9), 0, 0, 0, 0, '0, "R3");
        step('0, '0, '0, 0, 0, 0, 1, '1, "R2");
        // R5: hold ticks only while waiting
        for (int i = 0; i < 3; i++) step(one(40), '0, one(40), 1, 0, 0, 0, '0, "R5");
        step(one(40), '0, one(40), 0, 0, 0, 0, '0, "R5");
        // R6: close a held cycle, then one with no hold
        step('0, '0, '0, 0, 1, 0, 0, '0, "R6");
        step('0, '0, '0, 1, 1, 0, 0, '0, "R6");
        // R6: hold tick and cycle end together
        step(one(77), '0, one(77), 1, 1, 0, 0, '0, "R6");
        step('0, '0, '0, 0, 1, 0, 0, '0, "R6");
        // R8: clear together with a hold tick keeps the pending record
        step(one(77), '0, one(77), 1, 0, 1, 0, '0, "R8");
        step('0, '0, '0, 0, 1, 0, 0, '0, "R8");
        // R7: saturation of both counters
        for (int i = 0; i < 70; i++) step(one(i), '0, one(i), 1, 0, 0, 0, '0, "R7");
        for (int i = 0; i < 70; i++) step(one(12), '0, one(12), 1, 1, 0, 0, '0, "R7");
        step('0, '0, '0, 0, 0, 1, 0, '0, "R8");
        step('0, '0, '0, 0, 0, 0, 0, '0, "R1");
        @(negedge clk);
        @(negedge clk);
        #2;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule